// File: doc/BRIEF.md
# Lockstep Single-Event-Upset Injection Controller

This block runs one fault-injection experiment at a time. It holds two copies of a small sequential design under test, a reference copy and a faulty copy. From a start pulse onward, it reads stored input vectors from an external synchronous memory port and feeds each vector to both copies on the same clock cycle, from address 0 up to a programmed last address. At a selected cycle it inverts one or more selected flip-flops of the faulty copy for that one edge only. It then watches for the first cycle in which the outputs of the two copies disagree.

Each run ends with a class code: damage, latent or no fault. For damage, the block also reports the number of cycles between the injection and the first output disagreement. The injection cycle and the flip-flop index are either taken from configuration inputs or drawn from a seedable 32-bit LFSR, and the two choices are made independently. A host reads the held results once `done` rises. The next start pulse clears both copies together, so every run begins with the two copies in lockstep.

The controller has four states. `ST_IDLE` waits for `start` and goes to `ST_ARM`. `ST_ARM` fixes the targets and issues the read of vector 0, then goes to `ST_RUN`. `ST_RUN` goes to `ST_IDLE` on an output mismatch and to `ST_CHECK` once the last vector has been applied. `ST_CHECK` always returns to `ST_IDLE`.

Top module: `seu_campaign_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until the first start, `done`=0, `busy`=0, `fault_class`=00 and `vec_rd_en`=0. `busy` and `done` are never high together.
- R2: A run that reaches its last vector L reads addresses 0,1,...,L, one per cycle and in that order. That is L+1 reads in total, and each read returns data one cycle later.
- R3: Each copy holds NFF flip-flops. On every applied vector the copy rotates its state left by one bit and XORs in the vector folded to NFF bits, where vector bit i lands on state bit i mod NFF. The copy's output is its low OUT_W state bits. An injection at cycle T inverts the selected faulty bits at the edge that ends cycle T. The outputs are compared in every run cycle after that edge and once more after the last vector. The first mismatch gives class 01 (damage) with latency = mismatch cycle − T, so a mismatch in cycle T+1 reports 1.
- R4: With deterministic selection, `res_inj_cycle` equals `cfg_inj_cycle` and `res_inj_reg` equals `cfg_inj_reg`.
- R5: In latent mode (`cfg_latent`=1), a run that ends with no output mismatch but with unequal copy states gives class 10 (latent).
- R6: In damage mode (`cfg_latent`=0), a run with no output mismatch gives class 00, even when the copy states differ.
- R7: An injection cycle greater than the last vector index causes no flip, and the run gives class 00 in either mode.
- R8: `cfg_seu_count`=n flips the registers R, R+1, ..., R+n−1 (mod NFF) all at the injection cycle. A count of 0 acts as 1.
- R9: Random time selection gives a cycle in [`cfg_inj_cycle`, `cfg_inj_cycle`+`cfg_cycle_span`−1], or exactly `cfg_inj_cycle` when the span is 0. Random location selection gives a register index below `cfg_reg_count`.
- R10: A start with `cfg_seed_load`=1 reloads the LFSR from `cfg_seed`, so two such runs with the same seed pick the same cycle and register.
- R11: `done`, `fault_class`, `res_latency`, `res_inj_cycle` and `res_inj_reg` hold their values until the next start. A start clears `done`, `fault_class` and `res_latency` and puts both copies in the same state.
- R12: `fault_class` takes only the values 00, 01 and 10. Latency is 0 for any class other than damage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run; ignored while busy |
| cfg_latent | input | 1 | 1 selects latent analysis, 0 selects damage analysis |
| cfg_rand_time | input | 1 | Draw the injection cycle from the LFSR |
| cfg_rand_loc | input | 1 | Draw the register index from the LFSR |
| cfg_seed_load | input | 1 | Reload the LFSR from cfg_seed at start |
| cfg_seed | input | 32 | LFSR seed (0 maps to a nonzero constant) |
| cfg_last_vec | input | ADDR_W | Index of the final vector |
| cfg_inj_cycle | input | ADDR_W | Injection cycle, or base of the random window |
| cfg_cycle_span | input | ADDR_W | Width of the random cycle window |
| cfg_inj_reg | input | IDX_W | Deterministic register index |
| cfg_reg_count | input | IDX_W+1 | Number of candidate registers for random choice |
| cfg_seu_count | input | IDX_W+1 | Flips per run (0 treated as 1) |
| vec_rd_en | output | 1 | Vector memory read strobe |
| vec_addr | output | ADDR_W | Vector memory address |
| vec_rd_data | input | VEC_W | Vector memory data, one cycle after the read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid |
| fault_class | output | 2 | 00 no fault, 01 damage, 10 latent |
| res_inj_cycle | output | ADDR_W | Cycle used for injection |
| res_inj_reg | output | IDX_W | First register flipped |
| res_latency | output | ADDR_W+1 | Cycles from injection to first mismatch |

## Verification
The bench builds the block with its defaults: 102-bit vectors, a 21-bit address, NFF=16 and OUT_W=4. With only 16 flip-flops and a 4-bit output window, a flip in the upper bits takes up to 13 cycles to reach the output. Injecting near the last vector therefore gives latent cases, late damage and first-cycle damage within 41-vector runs. With a run of only one vector (last index 0), the final compare after the last vector is exercised at its boundary.

// File: rtl/seu_pkg.sv
package seu_pkg;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'b00,
        CLS_DAMAGE = 2'b01,
        CLS_LATENT = 2'b10
    } fault_class_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_RUN,
        ST_CHECK
    } ctrl_state_t;

endpackage

// File: rtl/seu_lfsr.sv
module seu_lfsr #(
    parameter int          W    = 32,
    parameter logic [31:0] TAPS = 32'h8020_0003,
    parameter logic [31:0] INIT = 32'h0000_0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    input  logic         step_i,
    output logic [W-1:0] value_o
);

    logic [W-1:0] q;
    logic [W-1:0] nxt;

    // Galois form, shifting right
    always_comb begin
        nxt = {1'b0, q[W-1:1]};
        if (q[0]) begin
            nxt = nxt ^ TAPS[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= INIT[W-1:0];
        end else if (load_i) begin
            q <= (seed_i == '0) ? INIT[W-1:0] : seed_i;
        end else if (step_i) begin
            q <= nxt;
        end
    end

    assign value_o = q;

    // an all-zero register would freeze random selection (R9)
    assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);

endmodule

// File: rtl/seu_replica.sv
module seu_replica #(
    parameter int VEC_W = 102,
    parameter int NFF   = 16,
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic [NFF-1:0]   flip_i,
    output logic [NFF-1:0]   state_o,
    output logic [OUT_W-1:0] out_o
);

    logic [NFF-1:0] st_q;
    logic [NFF-1:0] fold;

    always_comb begin
        fold = '0;
        for (int i = 0; i < VEC_W; i++) begin
            fold[i % NFF] = fold[i % NFF] ^ vec_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (clr_i) begin
            st_q <= '0;
        end else if (en_i) begin
            st_q <= {st_q[NFF-2:0], st_q[NFF-1]} ^ fold ^ flip_i;
        end
    end

    assign state_o = st_q;
    assign out_o   = st_q[OUT_W-1:0];

    // a flip only lands on an edge that applies a vector (R8)
    assert_flip_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flip_i) |-> en_i);

endmodule

// File: rtl/seu_cmp.sv
module seu_cmp #(
    parameter int NFF   = 16,
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] ref_out_i,
    input  logic [OUT_W-1:0] flt_out_i,
    input  logic [NFF-1:0]   ref_state_i,
    input  logic [NFF-1:0]   flt_state_i,
    output logic             out_diff_o,
    output logic             state_diff_o
);

    assign out_diff_o   = (ref_out_i != flt_out_i);
    assign state_diff_o = (ref_state_i != flt_state_i);

    // outputs are a view of state: an output split needs a state split (R5)
    assert_out_implies_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_diff_o |-> state_diff_o);

endmodule

// File: rtl/seu_campaign_ctrl.sv
module seu_campaign_ctrl
    import seu_pkg::*;
#(
    parameter  int VEC_W  = 102,
    parameter  int ADDR_W = 21,
    parameter  int NFF    = 16,
    parameter  int OUT_W  = 4,
    localparam int IDX_W  = $clog2(NFF),
    localparam int CNT_W  = IDX_W + 1,
    localparam int LAT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_latent,
    input  logic              cfg_rand_time,
    input  logic              cfg_rand_loc,
    input  logic              cfg_seed_load,
    input  logic [31:0]       cfg_seed,
    input  logic [ADDR_W-1:0] cfg_last_vec,
    input  logic [ADDR_W-1:0] cfg_inj_cycle,
    input  logic [ADDR_W-1:0] cfg_cycle_span,
    input  logic [IDX_W-1:0]  cfg_inj_reg,
    input  logic [CNT_W-1:0]  cfg_reg_count,
    input  logic [CNT_W-1:0]  cfg_seu_count,
    output logic              vec_rd_en,
    output logic [ADDR_W-1:0] vec_addr,
    input  logic [VEC_W-1:0]  vec_rd_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        fault_class,
    output logic [ADDR_W-1:0] res_inj_cycle,
    output logic [IDX_W-1:0]  res_inj_reg,
    output logic [LAT_W-1:0]  res_latency
);

    ctrl_state_t st_q, st_d;

    // configuration captured at start
    logic              latent_q, rtime_q, rloc_q;
    logic [ADDR_W-1:0] last_q, base_q, span_q;
    logic [IDX_W-1:0]  reg_q;
    logic [CNT_W-1:0]  rcnt_q, nseu_q;

    // run state
    logic [ADDR_W-1:0] cyc_q, tgt_cyc_q;
    logic [IDX_W-1:0]  tgt_reg_q;

    logic        kick;
    logic [31:0] rnd;
    logic [16+ADDR_W-1:0] t_prod;
    logic [16+CNT_W-1:0]  r_prod;
    logic [ADDR_W-1:0]    t_scaled;
    logic [CNT_W-1:0]     r_scaled;

    logic [CNT_W-1:0] n_eff;
    logic [NFF-1:0]   ones;
    logic [2*NFF-1:0] wide;
    logic [NFF-1:0]   hit_mask;

    logic           rep_en, rep_clr;
    logic [NFF-1:0] flip_mask;
    logic [NFF-1:0]   st_copy  [2];
    logic [OUT_W-1:0] out_copy [2];
    logic           out_diff, st_diff;

    assign kick = start && (st_q == ST_IDLE);
    assign busy = (st_q != ST_IDLE);

    seu_lfsr #(.W(32)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (kick && cfg_seed_load),
        .seed_i  (cfg_seed),
        .step_i  (kick),
        .value_o (rnd)
    );

    // scale the random halves into the programmed ranges
    assign t_prod   = {{ADDR_W{1'b0}}, rnd[31:16]} * {16'b0, span_q};
    assign r_prod   = {{CNT_W{1'b0}}, rnd[15:0]} * {16'b0, rcnt_q};
    assign t_scaled = ADDR_W'(t_prod >> 16);
    assign r_scaled = CNT_W'(r_prod >> 16);

    // contiguous flip mask, wrapping past the top register
    always_comb begin
        n_eff = (nseu_q == '0) ? CNT_W'(1) : nseu_q;
        for (int i = 0; i < NFF; i++) begin
            ones[i] = (CNT_W'(i) < n_eff);
        end
        wide     = {{NFF{1'b0}}, ones} << tgt_reg_q;
        hit_mask = wide[NFF-1:0] | wide[2*NFF-1:NFF];
    end

    for (genvar g = 0; g < 2; g++) begin : g_copy
        seu_replica #(.VEC_W(VEC_W), .NFF(NFF), .OUT_W(OUT_W)) u_rep (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (rep_clr),
            .en_i    (rep_en),
            .vec_i   (vec_rd_data),
            .flip_i  ((g == 1) ? flip_mask : {NFF{1'b0}}),
            .state_o (st_copy[g]),
            .out_o   (out_copy[g])
        );
    end

    seu_cmp #(.NFF(NFF), .OUT_W(OUT_W)) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_out_i    (out_copy[0]),
        .flt_out_i    (out_copy[1]),
        .ref_state_i  (st_copy[0]),
        .flt_state_i  (st_copy[1]),
        .out_diff_o   (out_diff),
        .state_diff_o (st_diff)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_ARM;
            ST_ARM:   st_d = ST_RUN;
            ST_RUN: begin
                if (out_diff)              st_d = ST_IDLE;
                else if (cyc_q == last_q)  st_d = ST_CHECK;
            end
            ST_CHECK: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // per-state outputs
    always_comb begin
        vec_rd_en = 1'b0;
        vec_addr  = '0;
        rep_en    = 1'b0;
        rep_clr   = 1'b0;
        flip_mask = '0;
        unique case (st_q)
            ST_IDLE:  rep_clr = start;
            ST_ARM:   vec_rd_en = 1'b1;
            ST_RUN: begin
                rep_en    = 1'b1;
                vec_rd_en = (cyc_q != last_q) && !out_diff;
                vec_addr  = cyc_q + ADDR_W'(1);
                if (cyc_q == tgt_cyc_q) flip_mask = hit_mask;
            end
            ST_CHECK: ;
            default:  ;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latent_q <= 1'b0; rtime_q <= 1'b0; rloc_q <= 1'b0;
            last_q <= '0; base_q <= '0; span_q <= '0;
            reg_q <= '0; rcnt_q <= '0; nseu_q <= '0;
            cyc_q <= '0; tgt_cyc_q <= '0; tgt_reg_q <= '0;
            done <= 1'b0; fault_class <= CLS_NONE;
            res_inj_cycle <= '0; res_inj_reg <= '0; res_latency <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    latent_q <= cfg_latent;
                    rtime_q  <= cfg_rand_time;
                    rloc_q   <= cfg_rand_loc;
                    last_q   <= cfg_last_vec;
                    base_q   <= cfg_inj_cycle;
                    span_q   <= cfg_cycle_span;
                    reg_q    <= cfg_inj_reg;
                    rcnt_q   <= cfg_reg_count;
                    nseu_q   <= cfg_seu_count;
                    done        <= 1'b0;
                    fault_class <= CLS_NONE;
                    res_latency <= '0;
                end
                ST_ARM: begin
                    tgt_cyc_q     <= rtime_q ? base_q + t_scaled : base_q;
                    tgt_reg_q     <= rloc_q ? IDX_W'(r_scaled) : reg_q;
                    res_inj_cycle <= rtime_q ? base_q + t_scaled : base_q;
                    res_inj_reg   <= rloc_q ? IDX_W'(r_scaled) : reg_q;
                    cyc_q         <= '0;
                end
                ST_RUN: begin
                    if (out_diff) begin
                        done        <= 1'b1;
                        fault_class <= CLS_DAMAGE;
                        res_latency <= {1'b0, cyc_q} - {1'b0, tgt_cyc_q};
                    end else if (cyc_q != last_q) begin
                        cyc_q <= cyc_q + ADDR_W'(1);
                    end
                end
                ST_CHECK: begin
                    done <= 1'b1;
                    if (out_diff) begin
                        fault_class <= CLS_DAMAGE;
                        res_latency <= {1'b0, cyc_q} + LAT_W'(1) - {1'b0, tgt_cyc_q};
                    end else if (latent_q && st_diff) begin
                        fault_class <= CLS_LATENT;
                    end else begin
                        fault_class <= CLS_NONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && vec_rd_en) |-> vec_addr == $past(vec_addr) + ADDR_W'(1));

    assert_damage_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_class == CLS_DAMAGE) |-> res_latency != '0);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !start) |=> ($stable(done) && $stable(fault_class)
                                          && $stable(res_latency)));

    assert_class_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault_class != 2'b11);

endmodule

// File: tb/seu_campaign_ctrl_tb.sv
`timescale 1ns/1ps
module seu_campaign_ctrl_tb;

    localparam int VEC_W  = 102;
    localparam int ADDR_W = 21;
    localparam int NFF    = 16;
    localparam int OUT_W  = 4;
    localparam int IDX_W  = $clog2(NFF);
    localparam int CNT_W  = IDX_W + 1;
    localparam int LAT_W  = ADDR_W + 1;

    typedef struct packed {
        logic [3:0]       req;
        logic             lat;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] cyc;
        logic [IDX_W-1:0]  rg;
        logic [CNT_W-1:0]  n;
        logic [1:0]        cls;
        logic [LAT_W-1:0]  elat;
    } case_t;

    // req, latent, last, cycle, reg, count, class, latency
    localparam case_t CASES [0:10] = '{
        '{4'd3,  1'b0, 21'd40, 21'd5,  4'd2,  5'd1, 2'b01, 22'd1},
        '{4'd3,  1'b0, 21'd40, 21'd5,  4'd10, 5'd1, 2'b01, 22'd7},
        '{4'd6,  1'b0, 21'd40, 21'd30, 4'd4,  5'd1, 2'b00, 22'd0},
        '{4'd5,  1'b1, 21'd40, 21'd30, 4'd4,  5'd1, 2'b10, 22'd0},
        '{4'd3,  1'b1, 21'd40, 21'd40, 4'd0,  5'd1, 2'b01, 22'd1},
        '{4'd7,  1'b1, 21'd40, 21'd45, 4'd3,  5'd1, 2'b00, 22'd0},
        '{4'd8,  1'b0, 21'd40, 21'd3,  4'd15, 5'd2, 2'b01, 22'd1},
        '{4'd8,  1'b0, 21'd40, 21'd3,  4'd14, 5'd2, 2'b01, 22'd2},
        '{4'd8,  1'b1, 21'd40, 21'd3,  4'd5,  5'd3, 2'b01, 22'd10},
        '{4'd5,  1'b1, 21'd0,  21'd0,  4'd15, 5'd1, 2'b10, 22'd0},
        '{4'd8,  1'b0, 21'd40, 21'd5,  4'd2,  5'd0, 2'b01, 22'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_latent = 1'b0, cfg_rand_time = 1'b0, cfg_rand_loc = 1'b0, cfg_seed_load = 1'b0;
    logic [31:0]       cfg_seed = '0;
    logic [ADDR_W-1:0] cfg_last_vec = '0, cfg_inj_cycle = '0, cfg_cycle_span = '0;
    logic [IDX_W-1:0]  cfg_inj_reg = '0;
    logic [CNT_W-1:0]  cfg_reg_count = '0, cfg_seu_count = '0;
    logic              vec_rd_en;
    logic [ADDR_W-1:0] vec_addr;
    logic [VEC_W-1:0]  vec_rd_data = '0;
    logic              busy, done;
    logic [1:0]        fault_class;
    logic [ADDR_W-1:0] res_inj_cycle;
    logic [IDX_W-1:0]  res_inj_reg;
    logic [LAT_W-1:0]  res_latency;

    int n_tests = 0;
    int n_fail  = 0;
    int rd_total = 0;
    int rd_next  = 0;
    logic order_bad = 1'b0;

    always #2.5 clk = ~clk;

    seu_campaign_ctrl #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .NFF(NFF), .OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_latent(cfg_latent), .cfg_rand_time(cfg_rand_time), .cfg_rand_loc(cfg_rand_loc),
        .cfg_seed_load(cfg_seed_load), .cfg_seed(cfg_seed), .cfg_last_vec(cfg_last_vec),
        .cfg_inj_cycle(cfg_inj_cycle), .cfg_cycle_span(cfg_cycle_span),
        .cfg_inj_reg(cfg_inj_reg), .cfg_reg_count(cfg_reg_count), .cfg_seu_count(cfg_seu_count),
        .vec_rd_en(vec_rd_en), .vec_addr(vec_addr), .vec_rd_data(vec_rd_data),
        .busy(busy), .done(done), .fault_class(fault_class),
        .res_inj_cycle(res_inj_cycle), .res_inj_reg(res_inj_reg), .res_latency(res_latency)
    );

    // synchronous vector memory model, content computed from the address
    always @(posedge clk) begin
        if (vec_rd_en)
            vec_rd_data <= {{(VEC_W-ADDR_W){vec_addr[0]}}, vec_addr ^ 21'h15A5A};
    end

    // read-order monitor
    always @(negedge clk) begin
        if (vec_rd_en) begin
            if (int'(vec_addr) != rd_next) order_bad <= 1'b1;
            rd_next  <= rd_next + 1;
            rd_total <= rd_total + 1;
        end else if (!busy) begin
            rd_next <= 0;
        end
    end

    task automatic summary_and_end();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input logic lat, input logic rt, input logic rl, input logic sl,
                            input logic [31:0] seed, input logic [ADDR_W-1:0] last,
                            input logic [ADDR_W-1:0] cyc, input logic [ADDR_W-1:0] span,
                            input logic [IDX_W-1:0] rg, input logic [CNT_W-1:0] rc,
                            input logic [CNT_W-1:0] n);
        int waited;
        @(negedge clk);
        cfg_latent = lat; cfg_rand_time = rt; cfg_rand_loc = rl; cfg_seed_load = sl;
        cfg_seed = seed; cfg_last_vec = last; cfg_inj_cycle = cyc; cfg_cycle_span = span;
        cfg_inj_reg = rg; cfg_reg_count = rc; cfg_seu_count = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        if (!done) check("R3 run timeout", 0, 1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finish");
        summary_and_end();
    end

    initial begin
        logic [ADDR_W-1:0] c_a;
        logic [IDX_W-1:0]  r_a;
        int rd_before;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done in reset", done, 0);
        check("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 class after reset", fault_class, 0);
        check("R1 read strobe idle", vec_rd_en, 0);

        // table walk: R3 R4 R5 R6 R7 R8 R12
        for (int i = 0; i <= 10; i++) begin
            string tag;
            tag = $sformatf("R%0d case %0d", CASES[i].req, i);
            rd_before = rd_total;
            run_case(CASES[i].lat, 1'b0, 1'b0, 1'b0, 32'h0, CASES[i].last, CASES[i].cyc,
                     21'd0, CASES[i].rg, 5'd16, CASES[i].n);
            check({tag, " class"}, fault_class, CASES[i].cls);      // R12 codes
            check({tag, " latency"}, res_latency, CASES[i].elat);
            check({"R4 cycle ", tag}, res_inj_cycle, CASES[i].cyc);
            check({"R4 reg ", tag}, res_inj_reg, CASES[i].rg);
            if (i == 2) begin
                // R2: full run reads 0..40 in order
                check("R2 read count", rd_total - rd_before, 41);
                check("R2 read order", order_bad, 0);
            end
        end

        // R11: results hold without a start
        repeat (8) @(negedge clk);
        check("R11 done held", done, 1);
        check("R11 class held", fault_class, 1);
        check("R11 latency held", res_latency, 1);

        // R9: random window and register range
        for (int k = 0; k < 4; k++) begin
            run_case(1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 21'd300, 21'd100, 21'd50, 4'd0, 5'd5, 5'd1);
            check("R9 cycle low", res_inj_cycle >= 100, 1);
            check("R9 cycle high", res_inj_cycle <= 149, 1);
            check("R9 reg range", res_inj_reg < 5, 1);
        end
        run_case(1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 21'd60, 21'd20, 21'd0, 4'd7, 5'd5, 5'd1);
        check("R9 zero span", res_inj_cycle, 20);

        // R10: same seed, same choice
        run_case(1'b1, 1'b1, 1'b1, 1'b1, 32'h1234_5678, 21'd300, 21'd10, 21'd200, 4'd0, 5'd16, 5'd1);
        c_a = res_inj_cycle;
        r_a = res_inj_reg;
        run_case(1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 21'd300, 21'd10, 21'd200, 4'd0, 5'd16, 5'd1);
        run_case(1'b1, 1'b1, 1'b1, 1'b1, 32'h1234_5678, 21'd300, 21'd10, 21'd200, 4'd0, 5'd16, 5'd1);
        check("R10 seed cycle", res_inj_cycle, c_a);
        check("R10 seed reg", res_inj_reg, r_a);

        // R11: a fresh start gives the lockstep result again
        run_case(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 21'd40, 21'd5, 21'd0, 4'd10, 5'd16, 5'd1);
        check("R11 rerun latency", res_latency, 7);
        check("R1 busy clear at done", busy, 0);

        summary_and_end();
    end

endmodule